// File: doc/BRIEF.md
# Multi-Mode PWM and Capture Timer Array

The block holds four timer slices behind one small synchronous register port. Each slice counts ticks from its own 8-bit clock divider. It can run in one of three modes. In split mode it acts as two independent 8-bit PWM generators. In wide mode it acts as one 16-bit PWM generator. In capture mode it is a free-running 16-bit counter whose value is latched by either of two input pins.

Software picks a slice's mode, sets its divider and loads its duty and period values, then sets the run bit. Duty and period writes are held in pending registers while a slice runs. They reach the comparators only when the counter wraps, so a running waveform never shows a shortened or stretched cycle. Capture events raise sticky flags. Each slice reports its flags on its own interrupt line.

Top module: `tmr_array`

## Requirements
- R1: The slice is selected by addr[4:3], and addr[2:0] picks a register in that slice. Offset 0 is control: bits[1:0] hold the mode (0 split 8-bit PWM, 1 wide 16-bit PWM, 2 capture), bit2 is run, bit3 selects the falling edge for capture pin A and bit4 does the same for pin B (0 means rising). Offset 1 is the divider, 2 is duty and 3 is period. Offset 4 reads the counter, 5 and 6 read the two capture values, and 7 holds the flags (bit0 for A, bit1 for B). Reads are combinational, and writes take effect at the clock edge where wr_en is high.
- R2: After reset every register reads 0, all pwm_out pins are low and all irq lines are low.
- R3: With divider value N, a running slice's counter advances once every N+1 clocks. A stopped slice holds its counter at 0.
- R4: In wide mode the counter runs from 0 to period and then wraps. Pin 2s is high while the counter is below duty, and pin 2s+1 stays low. A duty of 0 keeps the pin low, and a duty above period keeps it high.
- R5: In split mode the low bytes of counter, duty and period form channel 0 on pin 2s, and the high bytes form an independent channel 1 on pin 2s+1. Each byte counter wraps at its own period byte.
- R6: While a slice runs, duty and period writes reach the comparators only when the counter wraps, and each byte lane in split mode reloads at its own wrap. While a slice is stopped, the values are taken at once.
- R7: In capture mode each pin passes through a two-flop synchronizer. Its selected edge copies the counter into its capture register and sets its flag. The edge that is not selected has no effect.
- R8: A flag stays set until a control write of 1 to its bit at offset 7. irq[s] is the OR of slice s's two flags.
- R9: A control write whose mode differs from the current mode stores the new mode with run forced to 0 and clears the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Slice select [4:3], register offset [2:0] |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the addressed register |
| cap_in | input | 8 | Capture pins, two per slice (A = 2s, B = 2s+1) |
| pwm_out | output | 8 | PWM pins, two per slice |
| irq | output | 4 | Per-slice capture interrupt |

## Verification
The bench builds the array with its default of four slices, so the full 2-bit slice select is in use and every slice is addressed at least once. The vector table switches one slice between wide and split modes to exercise the mode-change path. The 8-bit divider and 16-bit counter widths are fixed, so the vectors can use a period above 255 to cover the upper counter byte in wide mode. With the 16-bit period, double-buffered writes can be tested with a period long enough that an early reload would show up as a stray high level.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
    localparam int CNT_W  = 16;
    localparam int PSC_W  = 8;
    localparam int HALF_W = CNT_W / 2;

    typedef enum logic [1:0] {
        MODE_SPLIT8 = 2'd0,
        MODE_WIDE16 = 2'd1,
        MODE_CAPT   = 2'd2,
        MODE_RSVD   = 2'd3
    } tmode_e;

    // control word: [4] pin B falling, [3] pin A falling, [2] run, [1:0] mode
    typedef struct packed {
        logic   capb_fall;
        logic   capa_fall;
        logic   run;
        tmode_e mode;
    } ctrl_t;

    localparam logic [2:0] OFF_CTRL = 3'd0;
    localparam logic [2:0] OFF_PSC  = 3'd1;
    localparam logic [2:0] OFF_DUTY = 3'd2;
    localparam logic [2:0] OFF_PER  = 3'd3;
    localparam logic [2:0] OFF_CNT  = 3'd4;
    localparam logic [2:0] OFF_CAPA = 3'd5;
    localparam logic [2:0] OFF_CAPB = 3'd6;
    localparam logic [2:0] OFF_FLAG = 3'd7;

    function automatic logic edge_hit(input logic prev, input logic cur, input logic fall);
        return fall ? (prev & ~cur) : (~prev & cur);
    endfunction
endpackage

// File: rtl/tmr_prescale.sv
`timescale 1ns/1ps
module tmr_prescale #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [PSC_W-1:0] div,
    output logic             tick
);
    logic [PSC_W-1:0] pc;

    assign tick = en && (pc >= div);

    always_ff @(posedge clk) begin
        if (rst || !en)
            pc <= '0;
        else if (tick)
            pc <= '0;
        else
            pc <= pc + 1'b1;
    end

    // a nonzero divider never yields ticks on two neighbouring clocks
    assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && div != '0) |=> (!tick || div == '0));
endmodule

// File: rtl/tmr_capture.sv
`timescale 1ns/1ps
module tmr_capture #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         arm,
    input  logic         fall,
    input  logic         pin_in,
    input  logic [W-1:0] cnt,
    input  logic         clr,
    output logic [W-1:0] cap,
    output logic         flag
);
    import tmr_pkg::*;

    logic [2:0] sh;
    logic       hit;

    assign hit = arm && edge_hit(sh[2], sh[1], fall);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            cap  <= '0;
            flag <= 1'b0;
        end else begin
            sh <= {sh[1:0], pin_in};
            if (hit)
                cap <= cnt;
            if (hit)
                flag <= 1'b1;
            else if (clr)
                flag <= 1'b0;
        end
    end

    assert_capture_value_R7: assert property (@(posedge clk) disable iff (rst)
        hit |=> (cap == $past(cnt)));

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);
endmodule

// File: rtl/tmr_slice.sv
`timescale 1ns/1ps
module tmr_slice
    import tmr_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int PW = PSC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [2:0]    off,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] rdata,
    input  logic [1:0]    cap_in,
    output logic [1:0]    pwm,
    output logic          irq
);
    localparam int HW = CW / 2;

    ctrl_t         ctrl;
    logic [PW-1:0] psc;
    logic [CW-1:0] duty_pend, per_pend, duty_act, per_act, cnt;
    logic [CW-1:0] cap_val [2];
    logic [1:0]    flag;
    logic          tick, run, mode_chg, cap_arm;
    logic          lo_wrap, hi_wrap, full_wrap, ld_lo, ld_hi;

    assign run      = ctrl.run;
    assign mode_chg = wr_en && off == OFF_CTRL && wdata[1:0] != ctrl.mode;
    assign cap_arm  = run && ctrl.mode == MODE_CAPT;

    tmr_prescale #(.PSC_W(PW)) u_psc (
        .clk(clk), .rst(rst), .en(run), .div(psc), .tick(tick)
    );

    // register writes
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            psc       <= '0;
            duty_pend <= '0;
            per_pend  <= '0;
        end else if (wr_en) begin
            case (off)
                OFF_CTRL: ctrl <= mode_chg ? ctrl_t'({wdata[4:3], 1'b0, wdata[1:0]})
                                           : ctrl_t'(wdata[4:0]);
                OFF_PSC:  psc       <= wdata[PW-1:0];
                OFF_DUTY: duty_pend <= wdata;
                OFF_PER:  per_pend  <= wdata;
                default: ;
            endcase
        end
    end

    // wrap detection and shadow reload
    assign lo_wrap   = cnt[HW-1:0] == per_act[HW-1:0];
    assign hi_wrap   = cnt[CW-1:HW] == per_act[CW-1:HW];
    assign full_wrap = cnt == per_act;
    assign ld_lo = !run || (tick && ((ctrl.mode == MODE_SPLIT8 && lo_wrap) ||
                                     (ctrl.mode == MODE_WIDE16 && full_wrap)));
    assign ld_hi = !run || (tick && ((ctrl.mode == MODE_SPLIT8 && hi_wrap) ||
                                     (ctrl.mode == MODE_WIDE16 && full_wrap)));

    always_ff @(posedge clk) begin
        if (rst) begin
            duty_act <= '0;
            per_act  <= '0;
        end else begin
            if (ld_lo) begin
                duty_act[HW-1:0] <= duty_pend[HW-1:0];
                per_act[HW-1:0]  <= per_pend[HW-1:0];
            end
            if (ld_hi) begin
                duty_act[CW-1:HW] <= duty_pend[CW-1:HW];
                per_act[CW-1:HW]  <= per_pend[CW-1:HW];
            end
        end
    end

    // counter
    always_ff @(posedge clk) begin
        if (rst || !run || mode_chg)
            cnt <= '0;
        else if (tick) begin
            case (ctrl.mode)
                MODE_SPLIT8: begin
                    cnt[HW-1:0]  <= lo_wrap ? '0 : cnt[HW-1:0] + 1'b1;
                    cnt[CW-1:HW] <= hi_wrap ? '0 : cnt[CW-1:HW] + 1'b1;
                end
                MODE_WIDE16: cnt <= full_wrap ? '0 : cnt + 1'b1;
                MODE_CAPT:   cnt <= cnt + 1'b1;
                default: ;
            endcase
        end
    end

    // registered PWM pins
    always_ff @(posedge clk) begin
        if (rst || !run)
            pwm <= 2'b00;
        else begin
            case (ctrl.mode)
                MODE_SPLIT8: pwm <= {cnt[CW-1:HW] < duty_act[CW-1:HW],
                                     cnt[HW-1:0] < duty_act[HW-1:0]};
                MODE_WIDE16: pwm <= {1'b0, cnt < duty_act};
                default:     pwm <= 2'b00;
            endcase
        end
    end

    for (genvar i = 0; i < 2; i++) begin : g_cap
        tmr_capture #(.W(CW)) u_cap (
            .clk(clk), .rst(rst), .arm(cap_arm),
            .fall(i == 0 ? ctrl.capa_fall : ctrl.capb_fall),
            .pin_in(cap_in[i]), .cnt(cnt),
            .clr(wr_en && off == OFF_FLAG && wdata[i]),
            .cap(cap_val[i]), .flag(flag[i])
        );
    end

    assign irq = |flag;

    always_comb begin
        case (off)
            OFF_CTRL: rdata = {{(CW-5){1'b0}}, ctrl};
            OFF_PSC:  rdata = {{(CW-PW){1'b0}}, psc};
            OFF_DUTY: rdata = duty_pend;
            OFF_PER:  rdata = per_pend;
            OFF_CNT:  rdata = cnt;
            OFF_CAPA: rdata = cap_val[0];
            OFF_CAPB: rdata = cap_val[1];
            default:  rdata = {{(CW-2){1'b0}}, flag};
        endcase
    end

    assert_mode_clear_R9: assert property (@(posedge clk) disable iff (rst)
        mode_chg |=> (!ctrl.run && cnt == '0));

    assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (run && !tick) |=> ($stable(duty_act) && $stable(per_act)));

    assert_wide_bound_R4: assert property (@(posedge clk) disable iff (rst)
        (run && ctrl.mode == MODE_WIDE16) |-> (cnt <= per_act));
endmodule

// File: rtl/tmr_array.sv
`timescale 1ns/1ps
module tmr_array
    import tmr_pkg::*;
#(
    parameter int NUM_SUB = 4,
    parameter int ADDR_W  = $clog2(NUM_SUB) + 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [CNT_W-1:0]     wdata,
    output logic [CNT_W-1:0]     rdata,
    input  logic [2*NUM_SUB-1:0] cap_in,
    output logic [2*NUM_SUB-1:0] pwm_out,
    output logic [NUM_SUB-1:0]   irq
);
    localparam int SEL_W = ADDR_W - 3;

    logic [SEL_W-1:0] sel;
    logic [CNT_W-1:0] rd_arr [NUM_SUB];

    assign sel = addr[ADDR_W-1:3];

    for (genvar s = 0; s < NUM_SUB; s++) begin : g_sub
        tmr_slice #(.CW(CNT_W), .PW(PSC_W)) u_slice (
            .clk(clk), .rst(rst),
            .wr_en(wr_en && sel == SEL_W'(s)),
            .off(addr[2:0]), .wdata(wdata), .rdata(rd_arr[s]),
            .cap_in(cap_in[2*s +: 2]), .pwm(pwm_out[2*s +: 2]), .irq(irq[s])
        );
    end

    assign rdata = rd_arr[sel];

    // right after reset the array is quiet
    assert_reset_quiet_R2: assert property (@(posedge clk)
        $fell(rst) |-> (pwm_out == '0 && irq == '0));
endmodule

// File: tb/tmr_array_tb.sv
`timescale 1ns/1ps
module tmr_array_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [7:0]  cap_in = '0;
    logic [7:0]  pwm_out;
    logic [3:0]  irq;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    tmr_array u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .cap_in(cap_in), .pwm_out(pwm_out), .irq(irq)
    );

    typedef struct packed {
        logic [1:0]  sub;
        logic [1:0]  mode;
        logic [7:0]  psc;
        logic [15:0] duty;
        logic [15:0] per;
        logic [31:0] win;
        logic [31:0] hi0;
        logic [31:0] hi1;
    } vec_t;

    // mode 1 = wide (R4), mode 0 = split (R5)
    localparam vec_t VEC [6] = '{
        '{2'd0, 2'd1, 8'd0, 16'd3,      16'd9,      32'd40,   32'd12,  32'd0},
        '{2'd1, 2'd0, 8'd1, 16'h0502,   16'h0704,   32'd80,   32'd32,  32'd50},
        '{2'd2, 2'd1, 8'd3, 16'd0,      16'd4,      32'd40,   32'd0,   32'd0},
        '{2'd3, 2'd1, 8'd0, 16'd20,     16'd7,      32'd16,   32'd16,  32'd0},
        '{2'd2, 2'd0, 8'd0, 16'h0101,   16'h0303,   32'd16,   32'd4,   32'd4},
        '{2'd0, 2'd1, 8'd2, 16'h0100,   16'h01FF,   32'd1536, 32'd768, 32'd0}
    };

    task automatic check(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int sub, input int off, input int d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = 5'(sub * 8 + off);
        wdata = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int sub, input int off, output int d);
        @(negedge clk);
        addr = 5'(sub * 8 + off);
        #1 d = int'(rdata);
    endtask

    task automatic measure(input int pin0, input int win, output int h0, output int h1);
        h0 = 0;
        h1 = 0;
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            h0 += int'(pwm_out[pin0]);
            h1 += int'(pwm_out[pin0 + 1]);
        end
    endtask

    task automatic wait_rise(input int pin, output bit found);
        logic prev = pwm_out[pin];
        found = 0;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (pwm_out[pin] && !prev) begin
                found = 1;
                break;
            end
            prev = pwm_out[pin];
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int v, v2, h0, h1;
        bit found;

        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R2: reset state
        rd(3, 0, v);  check("R2 control after reset", v, 0);
        rd(0, 4, v);  check("R2 counter after reset", v, 0);
        check("R2 pwm pins after reset", int'(pwm_out), 0);
        check("R2 irq after reset", int'(irq), 0);

        // R1 R4 R5 R6: table of PWM vectors
        for (int k = 0; k < 6; k++) begin
            int sub = int'(VEC[k].sub);
            wr(sub, 0, int'(VEC[k].mode));
            wr(sub, 1, int'(VEC[k].psc));
            wr(sub, 2, int'(VEC[k].duty));
            wr(sub, 3, int'(VEC[k].per));
            wr(sub, 0, int'(VEC[k].mode) | 4);
            repeat (int'(VEC[k].win)) @(negedge clk);
            measure(2 * sub, int'(VEC[k].win), h0, h1);
            check($sformatf("R4/R5 vector %0d pin0 high count", k), h0, int'(VEC[k].hi0));
            check($sformatf("R4/R5 vector %0d pin1 high count", k), h1, int'(VEC[k].hi1));
        end

        // R3: divider 4 gives 10 ticks in 50 clocks; stopped counter holds 0
        wr(3, 0, 1);
        wr(3, 1, 4);
        wr(3, 2, 0);
        wr(3, 3, 16'hFFFF);
        wr(3, 0, 5);
        repeat (7) @(negedge clk);
        rd(3, 4, v);
        repeat (49) @(negedge clk);
        rd(3, 4, v2);
        check("R3 ticks in 50 clocks", v2 - v, 10);
        wr(3, 0, 1);
        rd(3, 4, v);
        check("R3 stopped counter", v, 0);

        // R6: mid-period writes wait for the wrap
        wr(0, 0, 1);
        wr(0, 1, 0);
        wr(0, 2, 2);
        wr(0, 3, 99);
        wr(0, 0, 5);
        wait_rise(0, found);
        check("R6 first rise seen", int'(found), 1);
        repeat (10) @(negedge clk);
        wr(0, 2, 60);
        wr(0, 3, 119);
        measure(0, 70, h0, h1);
        check("R6 no early duty change", h0, 0);
        wait_rise(0, found);
        measure(0, 240, h0, h1);
        check("R6 new waveform after wrap", h0 + 1 - int'(found), 120);

        // R7 R8: capture on slice 1, pin A rising, pin B falling
        wr(1, 0, 18);
        wr(1, 1, 0);
        wr(1, 0, 22);
        @(negedge clk); cap_in[3] = 1'b1;
        repeat (10) @(negedge clk);
        rd(1, 7, v);
        check("R7 unselected rising on pin B ignored", v, 0);
        @(negedge clk); cap_in[2] = 1'b1;
        repeat (37) @(negedge clk);
        cap_in[3] = 1'b0;
        repeat (6) @(negedge clk);
        rd(1, 7, v);
        check("R7 both flags set", v, 3);
        check("R8 irq of slice 1", int'(irq), 2);
        rd(1, 5, v);
        rd(1, 6, v2);
        check("R7 capture spacing", v2 - v, 37);
        @(negedge clk); cap_in[2] = 1'b0;
        repeat (6) @(negedge clk);
        rd(1, 5, v2);
        check("R7 falling edge on pin A ignored", v2, v);
        wr(1, 7, 1);
        rd(1, 7, v);
        check("R8 clear flag A only", v, 2);
        check("R8 irq held by flag B", int'(irq[1]), 1);
        wr(1, 7, 2);
        rd(1, 7, v);
        check("R8 all flags clear", v, 0);
        check("R8 irq released", int'(irq[1]), 0);

        // R9: mode change drops run and clears counter
        rd(1, 4, v);
        check("R9 counter running before change", int'(v != 0), 1);
        wr(1, 0, 5);
        rd(1, 0, v);
        check("R9 run forced low", v, 1);
        repeat (10) @(negedge clk);
        rd(1, 4, v);
        check("R9 counter cleared", v, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule